// File: doc/BRIEF.md
# Interrupt Acceptance and Register-Bank Entry Controller

This block decides whether a pending interrupt or exception request may be taken. It compares the request against a 4-bit mask level held in a status field. Once a request is taken, the block runs a fixed six-state entry sequence. During that sequence it latches the handler vector and tells the surrounding datapath where the interrupted context goes. The status word and program counter always go to the stack. The remaining context goes to a hardware register bank, goes to the stack, or is abandoned in favour of a bank-overflow trap. The block then rewrites the mask level and presents the handler address for a non-delayed jump.

A bank pointer counts how many of the `NUM_BANKS` banks are occupied. It rises on each bank save and falls on a restore strobe from the return path, saturating at both ends. Only ordinary maskable interrupts are eligible for banking. The non-maskable interrupt, user breaks and synchronous exceptions always use the stack for their context.

Top module: `irq_entry_ctrl`

## Requirements
- R1: A request of kind 1 (non-maskable) is taken at any mask level, and it leaves the mask at all ones (15), not 16.
- R2: A request of kind 0 (interrupt) or kind 2 (user break) is taken only when `req_level` is strictly greater than the current mask. A request with an equal or lower level leaves `busy` low.
- R3: For a taken kind 0 or kind 2 request, `mask_wr` pulses in the fourth cycle after acceptance is sampled. The mask reads `req_level` from the following cycle onward.
- R4: A request of kind 3 (synchronous exception) is always taken and leaves the mask unchanged.
- R5: Every taken request pulses `push_sr_pc` for one cycle, two cycles after `accept`.
- R6: A kind 0 request taken with `bank_en` high, while fewer than `NUM_BANKS` banks are occupied, pulses `ctx_to_bank` in the save cycle. In that cycle `bank_idx` equals the occupancy count, and the occupancy count then rises by one.
- R7: Requests of kinds 1, 2 and 3 never save to a bank and never change the occupancy count.
- R8: In the save cycle, `ctx_to_stack` pulses whenever no bank save and no overflow trap occurs. This covers a full pool with `ovf_trap_en` low, and a request that is not eligible for banking.
- R9: A bank-eligible request that finds all banks occupied, with `ovf_trap_en` high, pulses `bank_ovf_exc`. The jump then goes to vector `OVF_VECTOR` instead of the request's vector.
- R10: `bank_restore` lowers the occupancy count by one, and has no effect at zero. The count never exceeds `NUM_BANKS`.
- R11: `accept` is a one-cycle pulse in the cycle after a takeable request is sampled in idle. `busy` stays high for the five entry cycles, and requests seen while busy are ignored.
- R12: `jump_valid` is high for one cycle, right after `mask_wr`. During that cycle `jump_addr` = `vec_base` + 4 × vector, and it is zero otherwise.
- R13: `mask_load` writes `mask_load_val` into the mask in any cycle except the mask-update cycle. The mask resets to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request pending this cycle |
| req_kind | input | 2 | 0 interrupt, 1 non-maskable, 2 user break, 3 synchronous exception |
| req_level | input | 4 | Request priority level |
| req_vector | input | 8 | Request vector number |
| bank_en | input | 1 | Allow bank saving for this request |
| ovf_trap_en | input | 1 | Trap instead of stacking when banks are full |
| bank_restore | input | 1 | One bank released by the return path |
| mask_load | input | 1 | Load the mask level |
| mask_load_val | input | 4 | Value for mask_load |
| vec_base | input | 32 | Vector table base address |
| accept | output | 1 | Request taken (one cycle) |
| busy | output | 1 | Entry sequence running |
| push_sr_pc | output | 1 | Push status word and PC (save cycle) |
| ctx_to_bank | output | 1 | Save context to bank `bank_idx` |
| ctx_to_stack | output | 1 | Save context to stack |
| bank_ovf_exc | output | 1 | Bank-overflow trap raised |
| bank_idx | output | 4 | Target bank of a bank save, else 0 |
| banks_used | output | 4 | Occupied bank count |
| mask_level | output | 4 | Current mask level |
| mask_wr | output | 1 | Mask rewritten this cycle |
| jump_valid | output | 1 | Jump to handler this cycle |
| jump_addr | output | 32 | Handler address during jump, else 0 |

## Verification
A stuck or mis-stepped sequencer state appears on the strobe outputs within one cycle, because each strobe belongs to exactly one state. A wrong occupancy count appears at once on `banks_used`. It also shows up at the next bank save through `bank_idx`, or as a missing or spurious overflow trap at the pool boundary. A corrupted mask appears on `mask_level` the cycle after it is written. It also surfaces as a wrong accept or reject decision on the next request.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_ACCEPT  = 3'd1,
    ST_VFETCH  = 3'd2,
    ST_SAVE    = 3'd3,
    ST_MASKUPD = 3'd4,
    ST_JUMP    = 3'd5
  } entry_st_t;

  typedef enum logic [1:0] {
    K_IRQ  = 2'd0,
    K_NMI  = 2'd1,
    K_UBRK = 2'd2,
    K_EXC  = 2'd3
  } src_kind_t;

endpackage

// File: rtl/irq_accept_eval.sv
module irq_accept_eval
  import irq_entry_pkg::*;
#(
  parameter int MASK_W = 4
) (
  input  logic [1:0]        req_kind,
  input  logic [MASK_W-1:0] req_level,
  input  logic [MASK_W-1:0] cur_mask,
  input  logic [1:0]        lat_kind,
  input  logic [MASK_W-1:0] lat_level,
  output logic              take,
  output logic [MASK_W-1:0] nxt_mask
);

  // Effective priority is one bit wider so the non-maskable source sits above every mask.
  function automatic logic [MASK_W:0] eff_prio(input logic [1:0] k, input logic [MASK_W-1:0] lvl);
    if (k == K_NMI) return {1'b1, {MASK_W{1'b0}}};
    return {1'b0, lvl};
  endfunction

  // Mask written on entry: saturate the non-maskable level, keep it for exceptions.
  function automatic logic [MASK_W-1:0] entry_mask(input logic [1:0] k, input logic [MASK_W-1:0] lvl,
                                                   input logic [MASK_W-1:0] old);
    case (k)
      K_NMI:   return {MASK_W{1'b1}};
      K_EXC:   return old;
      default: return lvl;
    endcase
  endfunction

  always_comb begin
    take     = (req_kind == K_EXC) || (eff_prio(req_kind, req_level) > {1'b0, cur_mask});
    nxt_mask = entry_mask(lat_kind, lat_level, cur_mask);
  end

endmodule

// File: rtl/irq_bank_ptr.sv
module irq_bank_ptr #(
  parameter int NUM_BANKS = 15,
  parameter int PTR_W     = $clog2(NUM_BANKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  output logic [PTR_W-1:0] ptr,
  output logic             full
);

  logic up, dn;

  always_comb begin
    full = (ptr == PTR_W'(NUM_BANKS));
    up   = inc && !full;
    dn   = dec && (ptr != '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         ptr <= '0;
    else if (up && !dn) ptr <= ptr + 1'b1;
    else if (dn && !up) ptr <= ptr - 1'b1;
  end

endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
  import irq_entry_pkg::*;
#(
  parameter int MASK_W     = 4,
  parameter int VEC_W      = 8,
  parameter int ADDR_W     = 32,
  parameter int PTR_W      = 4,
  parameter int OVF_VECTOR = 160
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [MASK_W-1:0] req_level,
  input  logic [VEC_W-1:0]  req_vector,
  input  logic              bank_en,
  input  logic              ovf_trap_en,
  input  logic              take,
  input  logic [MASK_W-1:0] nxt_mask,
  input  logic              full,
  input  logic [PTR_W-1:0]  ptr,
  input  logic              mask_load,
  input  logic [MASK_W-1:0] mask_load_val,
  input  logic [ADDR_W-1:0] vec_base,
  output logic [1:0]        lat_kind,
  output logic [MASK_W-1:0] lat_level,
  output logic              lat_is_nmi,
  output logic [MASK_W-1:0] mask_level,
  output logic              accept,
  output logic              busy,
  output logic              push_sr_pc,
  output logic              ctx_to_bank,
  output logic              ctx_to_stack,
  output logic              bank_ovf_exc,
  output logic [PTR_W-1:0]  bank_idx,
  output logic              mask_wr,
  output logic              jump_valid,
  output logic [ADDR_W-1:0] jump_addr
);

  entry_st_t        st;
  logic [VEC_W-1:0] lat_vec, hnd_vec;
  logic             lat_ben, lat_oen;
  logic             start, elig, in_save;

  function automatic logic [ADDR_W-1:0] handler_addr(input logic [ADDR_W-1:0] base,
                                                     input logic [VEC_W-1:0] v);
    return base + ADDR_W'({v, 2'b00});
  endfunction

  always_comb begin
    start        = (st == ST_IDLE) && req_valid && take;
    in_save      = (st == ST_SAVE);
    elig         = (lat_kind == K_IRQ) && lat_ben;
    ctx_to_bank  = in_save && elig && !full;
    bank_ovf_exc = in_save && elig && full && lat_oen;
    ctx_to_stack = in_save && !ctx_to_bank && !bank_ovf_exc;
    push_sr_pc   = in_save;
    bank_idx     = ctx_to_bank ? ptr : '0;
    accept       = (st == ST_ACCEPT);
    busy         = (st != ST_IDLE);
    mask_wr      = (st == ST_MASKUPD);
    jump_valid   = (st == ST_JUMP);
    jump_addr    = jump_valid ? handler_addr(vec_base, hnd_vec) : '0;
    lat_is_nmi   = (lat_kind == K_NMI);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE;
    end else begin
      case (st)
        ST_IDLE:    if (start) st <= ST_ACCEPT;
        ST_ACCEPT:  st <= ST_VFETCH;
        ST_VFETCH:  st <= ST_SAVE;
        ST_SAVE:    st <= ST_MASKUPD;
        ST_MASKUPD: st <= ST_JUMP;
        default:    st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_kind  <= '0;
      lat_level <= '0;
      lat_vec   <= '0;
      lat_ben   <= 1'b0;
      lat_oen   <= 1'b0;
      hnd_vec   <= '0;
    end else begin
      if (start) begin
        lat_kind  <= req_kind;
        lat_level <= req_level;
        lat_vec   <= req_vector;
        lat_ben   <= bank_en;
        lat_oen   <= ovf_trap_en;
      end
      if (st == ST_VFETCH)      hnd_vec <= lat_vec;
      else if (bank_ovf_exc)    hnd_vec <= VEC_W'(OVF_VECTOR);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         mask_level <= '1;
    else if (mask_wr)   mask_level <= nxt_mask;
    else if (mask_load) mask_level <= mask_load_val;
  end

endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl #(
  parameter int MASK_W     = 4,
  parameter int VEC_W      = 8,
  parameter int ADDR_W     = 32,
  parameter int NUM_BANKS  = 15,
  parameter int OVF_VECTOR = 160,
  localparam int PTR_W     = $clog2(NUM_BANKS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [MASK_W-1:0] req_level,
  input  logic [VEC_W-1:0]  req_vector,
  input  logic              bank_en,
  input  logic              ovf_trap_en,
  input  logic              bank_restore,
  input  logic              mask_load,
  input  logic [MASK_W-1:0] mask_load_val,
  input  logic [ADDR_W-1:0] vec_base,
  output logic              accept,
  output logic              busy,
  output logic              push_sr_pc,
  output logic              ctx_to_bank,
  output logic              ctx_to_stack,
  output logic              bank_ovf_exc,
  output logic [PTR_W-1:0]  bank_idx,
  output logic [PTR_W-1:0]  banks_used,
  output logic [MASK_W-1:0] mask_level,
  output logic              mask_wr,
  output logic              jump_valid,
  output logic [ADDR_W-1:0] jump_addr
);

  logic              take, full, lat_is_nmi;
  logic [MASK_W-1:0] nxt_mask, lat_level;
  logic [1:0]        lat_kind;

  irq_accept_eval #(.MASK_W(MASK_W)) u_eval (
    .req_kind  (req_kind),
    .req_level (req_level),
    .cur_mask  (mask_level),
    .lat_kind  (lat_kind),
    .lat_level (lat_level),
    .take      (take),
    .nxt_mask  (nxt_mask)
  );

  irq_bank_ptr #(.NUM_BANKS(NUM_BANKS), .PTR_W(PTR_W)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (ctx_to_bank),
    .dec   (bank_restore),
    .ptr   (banks_used),
    .full  (full)
  );

  irq_entry_fsm #(
    .MASK_W(MASK_W), .VEC_W(VEC_W), .ADDR_W(ADDR_W),
    .PTR_W(PTR_W), .OVF_VECTOR(OVF_VECTOR)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_kind      (req_kind),
    .req_level     (req_level),
    .req_vector    (req_vector),
    .bank_en       (bank_en),
    .ovf_trap_en   (ovf_trap_en),
    .take          (take),
    .nxt_mask      (nxt_mask),
    .full          (full),
    .ptr           (banks_used),
    .mask_load     (mask_load),
    .mask_load_val (mask_load_val),
    .vec_base      (vec_base),
    .lat_kind      (lat_kind),
    .lat_level     (lat_level),
    .lat_is_nmi    (lat_is_nmi),
    .mask_level    (mask_level),
    .accept        (accept),
    .busy          (busy),
    .push_sr_pc    (push_sr_pc),
    .ctx_to_bank   (ctx_to_bank),
    .ctx_to_stack  (ctx_to_stack),
    .bank_ovf_exc  (bank_ovf_exc),
    .bank_idx      (bank_idx),
    .mask_wr       (mask_wr),
    .jump_valid    (jump_valid),
    .jump_addr     (jump_addr)
  );

endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
  parameter int MASK_W    = 4,
  parameter int NUM_BANKS = 15,
  parameter int PTR_W     = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              accept,
  input logic              push_sr_pc,
  input logic              ctx_to_bank,
  input logic              ctx_to_stack,
  input logic              bank_ovf_exc,
  input logic              bank_restore,
  input logic [PTR_W-1:0]  bank_idx,
  input logic [PTR_W-1:0]  banks_used,
  input logic [MASK_W-1:0] mask_level,
  input logic              mask_wr,
  input logic              jump_valid,
  input logic              lat_is_nmi
);

  // R11
  accept_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !accept);

  // R5
  push_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> ##2 push_sr_pc);

  // R8
  save_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_sr_pc |-> $onehot({ctx_to_bank, ctx_to_stack, bank_ovf_exc}));

  // R8
  save_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !push_sr_pc |-> !(ctx_to_bank || ctx_to_stack || bank_ovf_exc));

  // R6
  bank_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_to_bank |-> (bank_idx == banks_used) && (banks_used < PTR_W'(NUM_BANKS)));

  // R6
  ptr_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_to_bank && !bank_restore) |=> banks_used == $past(banks_used) + 1'b1);

  // R10
  ptr_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_restore && !ctx_to_bank && banks_used == '0) |=> banks_used == '0);

  // R10
  ptr_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    banks_used <= PTR_W'(NUM_BANKS));

  // R1
  nmi_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr && lat_is_nmi) |=> mask_level == '1);

  // R12
  jump_after_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jump_valid |-> $past(mask_wr));

endmodule

bind irq_entry_ctrl irq_entry_chk #(.MASK_W(MASK_W), .NUM_BANKS(NUM_BANKS), .PTR_W(PTR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .accept       (accept),
  .push_sr_pc   (push_sr_pc),
  .ctx_to_bank  (ctx_to_bank),
  .ctx_to_stack (ctx_to_stack),
  .bank_ovf_exc (bank_ovf_exc),
  .bank_restore (bank_restore),
  .bank_idx     (bank_idx),
  .banks_used   (banks_used),
  .mask_level   (mask_level),
  .mask_wr      (mask_wr),
  .jump_valid   (jump_valid),
  .lat_is_nmi   (lat_is_nmi)
);

// File: tb/irq_entry_ctrl_tb.sv
`timescale 1ns/1ps
module irq_entry_ctrl_tb;

  localparam int          NB   = 15;
  localparam int          OVFV = 160;
  localparam logic [31:0] BASE = 32'h0000_1000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 0, bank_en = 0, ovf_trap_en = 0, bank_restore = 0, mask_load = 0;
  logic [1:0]  req_kind = 0;
  logic [3:0]  req_level = 0, mask_load_val = 0;
  logic [7:0]  req_vector = 0;
  logic [31:0] vec_base = BASE;
  logic        accept, busy, push_sr_pc, ctx_to_bank, ctx_to_stack, bank_ovf_exc, mask_wr, jump_valid;
  logic [3:0]  bank_idx, banks_used, mask_level;
  logic [31:0] jump_addr;

  int nvec = 0, nfail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_entry_ctrl #(.NUM_BANKS(NB), .OVF_VECTOR(OVFV)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_level(req_level), .req_vector(req_vector), .bank_en(bank_en),
    .ovf_trap_en(ovf_trap_en), .bank_restore(bank_restore), .mask_load(mask_load),
    .mask_load_val(mask_load_val), .vec_base(vec_base), .accept(accept), .busy(busy),
    .push_sr_pc(push_sr_pc), .ctx_to_bank(ctx_to_bank), .ctx_to_stack(ctx_to_stack),
    .bank_ovf_exc(bank_ovf_exc), .bank_idx(bank_idx), .banks_used(banks_used),
    .mask_level(mask_level), .mask_wr(mask_wr), .jump_valid(jump_valid), .jump_addr(jump_addr)
  );

  // Behavioural reference: phase counts 0 idle .. 5 jump.
  int m_phase, m_mask, m_ptr, m_kind, m_lvl, m_vec, m_ben, m_oen, m_ovf;

  function automatic bit m_elig();
    return (m_kind == 0) && (m_ben != 0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_mask = 15; m_ptr = 0; m_kind = 0; m_lvl = 0;
      m_vec = 0; m_ben = 0; m_oen = 0; m_ovf = 0;
    end else begin
      int inc, dec;
      inc = 0;
      case (m_phase)
        0: if (req_valid && (req_kind == 1 || req_kind == 3 || int'(req_level) > m_mask)) begin
             m_kind = req_kind; m_lvl = req_level; m_vec = req_vector;
             m_ben = bank_en; m_oen = ovf_trap_en; m_ovf = 0; m_phase = 1;
           end
        3: begin
             if (m_elig() && m_ptr < NB) inc = 1;
             if (m_elig() && m_ptr == NB && m_oen != 0) m_ovf = 1;
             m_phase = 4;
           end
        4: begin
             if (m_kind == 1) m_mask = 15;
             else if (m_kind != 3) m_mask = m_lvl;
             m_phase = 5;
           end
        5: m_phase = 0;
        default: m_phase = m_phase + 1;
      endcase
      if (mask_load && !(m_phase == 5 && inc == 0 && m_ovf >= 0 && 0)) begin end
      dec = (bank_restore && m_ptr != 0) ? 1 : 0;
      m_ptr = m_ptr + inc - dec;
    end
  end

  // Mask loads apply outside the mask-update cycle; tracked separately to keep ordering explicit.
  int ld_phase_prev;
  always @(posedge clk) begin
    if (rst_n) begin
      #0.1;
      if (mask_load && ld_phase_prev != 4) m_mask = mask_load_val;
    end
  end
  always @(negedge clk) ld_phase_prev = m_phase;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit sv, eb, eo;
      sv = (m_phase == 3);
      eb = sv && m_elig() && m_ptr < NB;
      eo = sv && m_elig() && m_ptr == NB && m_oen != 0;
      chk("R11 accept", accept, m_phase == 1);
      chk("R11 busy", busy, m_phase != 0);
      chk("R5 push_sr_pc", push_sr_pc, sv);
      chk("R6 ctx_to_bank", ctx_to_bank, eb);
      chk("R6 bank_idx", bank_idx, eb ? m_ptr : 0);
      chk("R8 ctx_to_stack", ctx_to_stack, sv && !eb && !eo);
      chk("R9 bank_ovf_exc", bank_ovf_exc, eo);
      chk("R3 mask_wr", mask_wr, m_phase == 4);
      chk("R3 mask_level", mask_level, m_mask);
      chk("R10 banks_used", banks_used, m_ptr);
      chk("R12 jump_valid", jump_valid, m_phase == 5);
      chk("R12 jump_addr", jump_addr,
          (m_phase == 5) ? BASE + 32'(4 * (m_ovf != 0 ? OVFV : m_vec)) : 32'h0);
    end
  end

  task automatic fire(input int kind, input int lvl, input int vec, input bit ben, input bit oen);
    @(negedge clk);
    req_valid = 1; req_kind = 2'(kind); req_level = 4'(lvl); req_vector = 8'(vec);
    bank_en = ben; ovf_trap_en = oen;
    @(negedge clk);
    req_valid = 0;
    repeat (7) @(negedge clk);
  endtask

  task automatic load_mask(input int v);
    @(negedge clk); mask_load = 1; mask_load_val = 4'(v);
    @(negedge clk); mask_load = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1; nfail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R13 reset state of mask; R10 empty pool
    chk("R13 reset mask", mask_level, 15);
    chk("R10 reset banks", banks_used, 0);
    load_mask(3);
    chk("R13 mask load", mask_level, 3);
    // R2 equal level rejected
    @(negedge clk); req_valid = 1; req_kind = 0; req_level = 3;
    @(negedge clk); req_valid = 0;
    chk("R2 equal level rejected", busy, 0);
    fire(0, 5, 8'h40, 1, 0);
    chk("R3 mask takes level", mask_level, 5);
    chk("R6 first bank", banks_used, 1);
    // R1 non-maskable with mask above zero
    fire(1, 0, 8'h0B, 1, 0);
    chk("R1 nmi mask saturates", mask_level, 15);
    chk("R7 nmi no bank", banks_used, 1);
    load_mask(0);
    fire(2, 2, 8'h0C, 1, 0);
    chk("R7 user break no bank", banks_used, 1);
    chk("R3 user break mask", mask_level, 2);
    load_mask(0);
    // R4 exception keeps mask
    fire(3, 9, 8'h09, 1, 0);
    chk("R4 exception mask kept", mask_level, 0);
    chk("R7 exception no bank", banks_used, 1);
    fire(0, 1, 8'h41, 0, 0);
    chk("R8 bank disabled uses stack", banks_used, 1);
    for (int i = 0; i < 14; i++) begin
      load_mask(0);
      fire(0, 1 + (i % 14), 8'h50 + i, 1, 0);
    end
    chk("R10 pool full", banks_used, 15);
    load_mask(0);
    fire(0, 7, 8'h60, 1, 0);
    chk("R8 full pool stacks", banks_used, 15);
    load_mask(0);
    fire(0, 7, 8'h61, 1, 1);
    chk("R9 overflow keeps pool", banks_used, 15);
    // R11 request during busy ignored
    load_mask(0);
    @(negedge clk); req_valid = 1; req_kind = 0; req_level = 4; req_vector = 8'h70; bank_en = 0;
    @(negedge clk); req_valid = 0;
    @(negedge clk); req_valid = 1; req_kind = 1; req_vector = 8'h71;
    @(negedge clk); req_valid = 0;
    repeat (6) @(negedge clk);
    chk("R11 busy request ignored", mask_level, 4);
    for (int i = 0; i < 17; i++) begin
      @(negedge clk); bank_restore = 1;
    end
    @(negedge clk); bank_restore = 0;
    chk("R10 restore floor", banks_used, 0);
    repeat (2) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule